// File: doc/BRIEF.md
# Unsigned Multiply-Subtract Accumulator

This block is a small DSP accumulator datapath. It holds a bank of wide accumulators, 40 bits each and two of them by default. Each operation takes two 16-bit operands and forms their full unsigned product. When fractional mode is on, it doubles that product. The result is then folded into one accumulator, picked by an index. The fold can subtract the product from the accumulator, add it, or load the accumulator with the product. All results wrap modulo 2^40, with no sign extension anywhere.

A one-cycle `op_valid` strobe launches an operation. The accumulator changes on that same clock edge, and `done` is high for the following cycle. Fractional mode is a single bit held in a control word. A separate write strobe loads that word, and only bit 7 of the written data matters.

Top module: `umsb_acc`

## Requirements
- R1: Both operands are read as unsigned 16-bit numbers, and their product is kept at its full 32-bit width. For example, 0x8001 times 0xFFFF gives 0x8000_7FFF.
- R2: While fractional mode is on, the product is shifted left by one bit before use, giving a value of up to 33 bits.
- R3: Op code 2'b00 (subtract) replaces the selected accumulator with accumulator minus product, modulo 2^40. For example, 0x7F_FFFF_FFFF less 0x8001*0xFFFF gives 0x7F_7FFF_8000 with fractional mode off. With fractional mode on it gives 0x7E_FFFF_0001. Subtracting 1 from zero gives 0xFF_FFFF_FFFF.
- R4: Op code 2'b01 (add) replaces the selected accumulator with accumulator plus product, modulo 2^40.
- R5: Op code 2'b10 (load) writes the product, zero-extended to 40 bits, into the selected accumulator. This includes the doubled product when fractional mode is on.
- R6: Op code 2'b11 leaves every accumulator unchanged, but `done` still pulses.
- R7: `acc_sel` picks the accumulator. Accumulator k sits in bits [40k+39:40k] of `acc_all`. Every accumulator that is not selected keeps its value.
- R8: An operation is sampled on a rising edge where `op_valid` is 1, and it updates the accumulator on that edge. `done` is 1 for exactly the cycle after each such edge and 0 otherwise. While `op_valid` is 0, changes on `op_code`, `acc_sel` or the operands alter nothing.
- R9: A rising edge with `ctl_we` at 1 loads fractional mode from `ctl_wdata[7]`, and the other data bits are ignored. Writing 0x8085 turns the mode on and 0x8005 turns it off. An operation sampled on the same edge as a write still uses the old mode.
- R10: A synchronous reset (`rst` high on a rising edge) clears all accumulators, clears fractional mode and clears `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word data; bit 7 is fractional mode |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | 00 subtract, 01 add, 10 load, 11 no change |
| acc_sel | input | 1 | Accumulator index |
| opnd_a | input | 16 | First unsigned operand |
| opnd_b | input | 16 | Second unsigned operand |
| acc_all | output | 80 | All accumulators, accumulator k in bits [40k+39:40k] |
| done | output | 1 | One-cycle pulse after each accepted operation |

## Verification
The bench builds the block with its default parameters: 16-bit operands, 40-bit accumulators, two accumulators and the mode flag at bit 7. With these widths, a doubled product of nearly 2^33 can reach the top bits of the accumulator. A single subtract from zero shows wraparound. The two worked subtract cases are reachable exactly: the bench first walks an accumulator up to 0x7F_FFFF_FFFF with 256 subtracts of 2^31. With two accumulators, every operation can also be checked for leaving the other one untouched.

// File: rtl/umsb_acc.sv
module umsb_acc #(
  parameter int OPW      = 16,
  parameter int ACCW     = 40,
  parameter int NACC     = 2,
  parameter int CTLW     = 16,
  parameter int FRAC_BIT = 7,
  localparam int SELW    = (NACC > 1) ? $clog2(NACC) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_we,
  input  logic [CTLW-1:0]      ctl_wdata,
  input  logic                 op_valid,
  input  logic [1:0]           op_code,
  input  logic [SELW-1:0]      acc_sel,
  input  logic [OPW-1:0]       opnd_a,
  input  logic [OPW-1:0]       opnd_b,
  output logic [NACC*ACCW-1:0] acc_all,
  output logic                 done
);

  localparam int PW  = 2 * OPW;
  localparam int PSW = PW + 1;

  localparam logic [1:0] OP_SUB  = 2'b00;
  localparam logic [1:0] OP_ADD  = 2'b01;
  localparam logic [1:0] OP_LOAD = 2'b10;

  logic            frac_q;
  logic [PW-1:0]   prod;
  logic [PSW-1:0]  prod_s;
  logic [ACCW-1:0] prod_x;
  logic [ACCW-1:0] acc_r [NACC];
  logic [ACCW-1:0] cur;
  logic [ACCW-1:0] nxt;
  logic            wr_en;

  assign prod   = PW'(opnd_a) * PW'(opnd_b);
  assign prod_s = frac_q ? {prod, 1'b0} : {1'b0, prod};
  assign prod_x = ACCW'(prod_s);
  assign cur    = acc_r[acc_sel];
  assign wr_en  = op_valid && (op_code != 2'b11);

  always_comb begin
    case (op_code)
      OP_SUB:  nxt = cur - prod_x;
      OP_ADD:  nxt = cur + prod_x;
      OP_LOAD: nxt = prod_x;
      default: nxt = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frac_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= op_valid;
      if (ctl_we) frac_q <= ctl_wdata[FRAC_BIT];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NACC; k++) begin
      if (rst)
        acc_r[k] <= '0;
      else if (wr_en && (acc_sel == SELW'(k)))
        acc_r[k] <= nxt;
    end
  end

  for (genvar g = 0; g < NACC; g++) begin : g_out
    assign acc_all[g*ACCW +: ACCW] = acc_r[g];

    assert_unsel_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (op_valid && acc_sel != SELW'(g)) |=>
        acc_all[g*ACCW +: ACCW] == $past(acc_all[g*ACCW +: ACCW]));

    assert_load_zext_R5: assert property (@(posedge clk) disable iff (rst)
      (op_valid && acc_sel == SELW'(g) && op_code == OP_LOAD) |=>
        acc_all[g*ACCW +: ACCW] ==
          ((ACCW'($past(opnd_a)) * ACCW'($past(opnd_b))) << $past(frac_q)));
  end

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (acc_all == '0 && !done && !frac_q));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!done && $stable(acc_all)));

  assert_nop_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 2'b11) |=> $stable(acc_all));

  assert_mode_write_R9: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> frac_q == $past(ctl_wdata[FRAC_BIT]));

endmodule

// File: tb/umsb_acc_tb.sv
module umsb_acc_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        ctl_we;
  logic [15:0] ctl_wdata;
  logic        op_valid;
  logic [1:0]  op_code;
  logic        acc_sel;
  logic [15:0] opnd_a;
  logic [15:0] opnd_b;
  logic [79:0] acc_all;
  logic        done;

  always #4 clk = ~clk;

  umsb_acc dut_i (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .op_valid(op_valid), .op_code(op_code), .acc_sel(acc_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_all(acc_all), .done(done)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  bit          ended = 1'b0;
  logic [39:0] m_acc [2];
  bit          m_frac;

  // {frac, op, sel, a, b}
  localparam logic [35:0] VEC [10] = '{
    {1'b0, 2'b10, 1'b0, 16'hFFFF, 16'hFFFF},  // R5 load
    {1'b0, 2'b01, 1'b0, 16'h1234, 16'h5678},  // R4 add
    {1'b0, 2'b00, 1'b1, 16'h0001, 16'h0001},  // R3 wrap below zero
    {1'b1, 2'b01, 1'b1, 16'hFFFF, 16'hFFFF},  // R4 R2 wrap above top
    {1'b1, 2'b10, 1'b1, 16'hFFFF, 16'hFFFF},  // R5 doubled load
    {1'b1, 2'b11, 1'b0, 16'hFFFF, 16'hFFFF},  // R6 no change
    {1'b0, 2'b00, 1'b0, 16'h8001, 16'hFFFF},  // R3 R1
    {1'b1, 2'b01, 1'b0, 16'h0000, 16'hABCD},  // R4 zero product
    {1'b1, 2'b10, 1'b0, 16'h8000, 16'h8000},  // R5 R2
    {1'b0, 2'b00, 1'b1, 16'hFFFF, 16'h0001}   // R3 R7
  };

  function automatic logic [39:0] ref_next(logic [1:0] op, logic [39:0] acc,
                                           logic [15:0] a, logic [15:0] b, bit fr);
    logic [63:0] p;
    p = {48'd0, a} * {48'd0, b};
    if (fr) p = p << 1;
    case (op)
      2'b00:   return acc - p[39:0];
      2'b01:   return acc + p[39:0];
      2'b10:   return p[39:0];
      default: return acc;
    endcase
  endfunction

  task automatic chk(string req, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr_ctl(logic [15:0] d);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
    m_frac = d[7];
  endtask

  task automatic do_op(logic [1:0] op, logic sel, logic [15:0] a, logic [15:0] b, string req);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; acc_sel = sel; opnd_a = a; opnd_b = b;
    m_acc[sel] = ref_next(op, m_acc[sel], a, b, m_frac);
    @(negedge clk);
    op_valid = 1'b0;
    chk({req, " acc0"}, {40'd0, acc_all[39:0]}, {40'd0, m_acc[0]});
    chk({req, " R7 acc1"}, {40'd0, acc_all[79:40]}, {40'd0, m_acc[1]});
    chk("R8 done high", {79'd0, done}, 80'd1);
    @(negedge clk);
    chk("R8 done low", {79'd0, done}, 80'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R8 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [35:0] v;
    rst = 1'b1; ctl_we = 1'b0; ctl_wdata = '0; op_valid = 1'b0;
    op_code = '0; acc_sel = 1'b0; opnd_a = '0; opnd_b = '0;
    m_acc[0] = '0; m_acc[1] = '0; m_frac = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 reset accs", acc_all, 80'd0);
    chk("R10 reset done", {79'd0, done}, 80'd0);
    rst = 1'b0;

    for (int i = 0; i < 10; i++) begin
      v = VEC[i];
      if (v[35] != m_frac) wr_ctl(v[35] ? 16'h8085 : 16'h8005);
      case (v[34:33])
        2'b00:   do_op(v[34:33], v[32], v[31:16], v[15:0], "R3");
        2'b01:   do_op(v[34:33], v[32], v[31:16], v[15:0], "R4");
        2'b10:   do_op(v[34:33], v[32], v[31:16], v[15:0], "R5");
        default: do_op(v[34:33], v[32], v[31:16], v[15:0], "R6");
      endcase
    end

    // worked subtract cases on accumulator 1
    wr_ctl(16'h8005);
    do_op(2'b10, 1'b1, 16'h0000, 16'h0000, "R5");
    do_op(2'b00, 1'b1, 16'h0001, 16'h0001, "R3");
    chk("R3 wrap", {40'd0, acc_all[79:40]}, {40'd0, 40'hFF_FFFF_FFFF});
    wr_ctl(16'h8085);
    for (int i = 0; i < 256; i++) do_op(2'b00, 1'b1, 16'h8000, 16'h8000, "R2");
    chk("R2 walk", {40'd0, acc_all[79:40]}, {40'd0, 40'h7F_FFFF_FFFF});
    wr_ctl(16'h8005);
    do_op(2'b00, 1'b1, 16'h8001, 16'hFFFF, "R3");
    chk("R3 R1 case one", {40'd0, acc_all[79:40]}, {40'd0, 40'h7F_7FFF_8000});
    do_op(2'b01, 1'b1, 16'h8001, 16'hFFFF, "R4");
    chk("R4 restore", {40'd0, acc_all[79:40]}, {40'd0, 40'h7F_FFFF_FFFF});
    wr_ctl(16'h8085);
    do_op(2'b00, 1'b1, 16'h8001, 16'hFFFF, "R3");
    chk("R2 R3 case two", {40'd0, acc_all[79:40]}, {40'd0, 40'h7E_FFFF_0001});

    // write and op on the same edge: op uses old mode (on)
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 16'h0005;
    op_valid = 1'b1; op_code = 2'b10; acc_sel = 1'b0; opnd_a = 16'd2; opnd_b = 16'd3;
    @(negedge clk);
    ctl_we = 1'b0; op_valid = 1'b0;
    m_frac = 1'b0; m_acc[0] = 40'd12;
    chk("R9 same-edge old mode", {40'd0, acc_all[39:0]}, 80'd12);
    do_op(2'b10, 1'b0, 16'd2, 16'd3, "R9");
    chk("R9 mode now off", {40'd0, acc_all[39:0]}, 80'd6);
    wr_ctl(16'h0080);
    do_op(2'b10, 1'b0, 16'd2, 16'd3, "R9");
    chk("R9 bit7 only sets", {40'd0, acc_all[39:0]}, 80'd12);
    wr_ctl(16'hFF7F);
    do_op(2'b10, 1'b0, 16'd2, 16'd3, "R9");
    chk("R9 other bits ignored", {40'd0, acc_all[39:0]}, 80'd6);

    // inputs wiggle without valid
    @(negedge clk);
    op_code = 2'b01; acc_sel = 1'b0; opnd_a = 16'hFFFF; opnd_b = 16'hFFFF;
    repeat (2) @(negedge clk);
    acc_sel = 1'b1; op_code = 2'b10;
    repeat (2) @(negedge clk);
    chk("R8 idle hold", acc_all, {m_acc[1], m_acc[0]});
    chk("R8 idle done", {79'd0, done}, 80'd0);

    // reset in mid-run clears accumulators and mode
    wr_ctl(16'h8085);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_acc[0] = '0; m_acc[1] = '0; m_frac = 1'b0;
    chk("R10 mid reset accs", acc_all, 80'd0);
    do_op(2'b10, 1'b0, 16'd2, 16'd3, "R10");
    chk("R10 mode cleared", {40'd0, acc_all[39:0]}, 80'd6);

    finish_run();
  end
endmodule